// File: doc/BRIEF.md
# Reorder Buffer Retirement Controller

This block keeps a small circular reorder buffer and retires instructions strictly in program order. Each cycle it can take up to a rename width of renamed instructions, each carrying a sequence number and type flags. Lanes that arrive already squashed are dropped. Execution reports finished work by buffer slot. Ready entries at the head then leave the buffer, up to a commit width per cycle. Every commit reports its sequence number back as done, and committing a load raises a pulse toward the load/store queue.

A store or non-speculative instruction is not executed early. When it reaches the head unexecuted, the block asks for it to be issued, parks it until execution reports it complete, and then commits it. A misprediction report from execution starts a squash. In that cycle the block echoes the redirect information to the earlier stages. Over the following cycles it walks back from the tail, removing at most two younger entries per cycle, then returns to normal running. The free-entry count is reported in every cycle.

Top module: `rob_commit`

## Requirements
- R1: After reset the free count equals DEPTH (8), renReady is high, and doneValid, squashOut, squashBusy, nonSpecValid and loadCommitted are low. The first instruction accepted goes into slot 0, and later ones take consecutive slots, wrapping modulo DEPTH.
- R2: renReady is high only while running, with no squash starting, and with free count >= RENW (2). When it is high, every lane with renValid=1 and renSquashed=0 is written in lane order into the next free slot. Squashed lanes use no slot. When renReady is low, the rename inputs are ignored.
- R3: A completion (cmplValid=1, cmplKill=0) sets the executed and can-commit bits of the given slot. It takes effect after that cycle's retirement, so the entry can commit one cycle later at the earliest.
- R4: Up to CMTW (2) entries retire per cycle, in order from the head, and retirement stops at the first head entry that is not ready. In a cycle with any commit, doneValid=1 and doneSeq holds the sequence number of the youngest entry committed in that cycle.
- R5: loadCommitted is high in exactly the cycles where a committed (not silently retired) entry has its load flag set.
- R6: An unexecuted store or non-speculative entry at the head does not retire. For one cycle, nonSpecValid=1 and nonSpecSeq holds its sequence number. Its can-commit bit is then cleared, so it makes no further request and commits after its completion arrives.
- R7: A completion with cmplKill=1 marks its slot as squashed and ready. If that entry reaches the head unexecuted, it blocks retirement. Once it has executed, it retires silently: no doneValid for it, no load pulse, and its slot is freed.
- R8: When exSquash=1 arrives while running, in the same cycle squashOut=1, squashBusy=1, doneValid=1 and doneSeq=exSquashSeq. The mispredict flag, taken flag, next PC and mispredicted PC appear on their outputs. Nothing is inserted or committed in that cycle. Outside such a cycle the echo outputs are zero.
- R9: In each following cycle the block removes up to 2 tail entries whose sequence number is younger than the squash point. "Younger" means a positive signed difference, so the test is safe across wraparound. In these cycles squashBusy=1, doneValid=1, and doneSeq is the new youngest entry (or the squash point if the buffer is empty). The first cycle that finds no younger tail entry has squashBusy=0 and returns to running. renReady is low in that cycle and can rise in the next one.
- R10: freeCount = DEPTH minus occupancy, reported in every cycle, including during a squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | RENW | Rename lane valid |
| renSquashed | input | RENW | Lane already squashed, skip it |
| renLoad | input | RENW | Lane is a load |
| renStore | input | RENW | Lane is a store |
| renNonSpec | input | RENW | Lane is non-speculative |
| renSeq | input | RENW*SEQW | Lane sequence numbers, lane 0 in the low bits |
| renReady | output | 1 | Rename lanes will be accepted this cycle |
| cmplValid | input | EXW | Completion notice valid |
| cmplKill | input | EXW | Completion marks the entry squashed instead of executed |
| cmplSlot | input | EXW*log2(DEPTH) | Slot index of each completion |
| exSquash | input | 1 | Misprediction squash request |
| exSquashSeq | input | SEQW | Sequence number of the squash point |
| exMispredict | input | 1 | Mispredict flag to echo |
| exTaken | input | 1 | Taken flag to echo |
| exNextPc | input | PCW | Redirect PC to echo |
| exMispredPc | input | PCW | Mispredicted PC to echo |
| freeCount | output | log2(DEPTH)+1 | Free entries |
| doneValid | output | 1 | doneSeq is meaningful |
| doneSeq | output | SEQW | Last committed, squash point, or walk tail sequence number |
| squashOut | output | 1 | Squash begins this cycle |
| squashBusy | output | 1 | Squash in progress |
| mispredictOut | output | 1 | Echoed mispredict flag |
| takenOut | output | 1 | Echoed taken flag |
| nextPcOut | output | PCW | Echoed redirect PC |
| mispredPcOut | output | PCW | Echoed mispredicted PC |
| nonSpecValid | output | 1 | Issue request for a parked head entry |
| nonSpecSeq | output | SEQW | Sequence number of that entry |
| loadCommitted | output | 1 | A load committed this cycle |

## Verification
The hardest state to reach from the ports is a squash walk that spans several cycles and also crosses the sequence-number wrap. This needs at least three younger entries behind a squash point close to the top of the number range. The stimulus inserts 254, 255, 0 and 1, then squashes at 254 while rename lanes are driven in the same cycle. The walk has to take two cycles, report 255 and then 254, and leave the rename lanes out. A second hard case is a killed head entry that must first block retirement and then leave silently once executed. This is reached by killing a load's slot before its completion.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int STRB_W = 4;

  typedef struct packed {
    logic canCommit;
    logic executed;
    logic squashed;
    logic isLoad;
    logic isStore;
    logic isNonSpec;
  } rob_flags_t;

  typedef struct packed {
    logic [STRB_W-1:0] retireCnt;
    logic              clrCan;
    logic [STRB_W-1:0] clrOffs;
    logic [STRB_W-1:0] popCnt;
    logic              insertEn;
  } rob_strobe_t;

  typedef enum logic {ST_RUN, ST_SQUASH} rob_state_e;
endpackage

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQW  = 8,
  parameter int RENW  = 2,
  parameter int EXW   = 2,
  parameter int CMTW  = 2,
  parameter int SQW   = 2,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rob_strobe_t       strb,
  input  logic [RENW-1:0]   renValid,
  input  logic [RENW-1:0]   renSquashed,
  input  logic [RENW-1:0]   renLoad,
  input  logic [RENW-1:0]   renStore,
  input  logic [RENW-1:0]   renNonSpec,
  input  logic [RENW*SEQW-1:0] renSeq,
  input  logic [EXW-1:0]    cmplValid,
  input  logic [EXW-1:0]    cmplKill,
  input  logic [EXW*PTRW-1:0] cmplSlot,
  output rob_flags_t        headFlags [CMTW],
  output logic [SEQW-1:0]   headSeq [CMTW],
  output logic [SEQW-1:0]   tailSeq [SQW+1],
  output logic [PTRW:0]     occCount
);
  rob_flags_t      flags [DEPTH];
  logic [SEQW-1:0] seqs  [DEPTH];
  logic [PTRW-1:0] headPtr, tailPtr;

  logic [PTRW-1:0] insSlot [RENW];
  logic [RENW-1:0] insDo;
  logic [PTRW:0]   insCnt;

  // Read windows: head side for retirement, tail side for the squash walk
  for (genvar k = 0; k < CMTW; k++) begin : g_head
    assign headFlags[k] = flags[headPtr + PTRW'(k)];
    assign headSeq[k]   = seqs[headPtr + PTRW'(k)];
  end
  for (genvar k = 0; k <= SQW; k++) begin : g_tail
    assign tailSeq[k] = seqs[tailPtr - PTRW'(k + 1)];
  end

  // Compact surviving rename lanes onto consecutive slots
  always_comb begin
    insCnt = '0;
    for (int i = 0; i < RENW; i++) begin
      insDo[i]   = strb.insertEn && renValid[i] && !renSquashed[i];
      insSlot[i] = tailPtr + insCnt[PTRW-1:0];
      if (insDo[i]) insCnt = insCnt + (PTRW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      occCount <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        flags[d] <= '0;
        seqs[d]  <= '0;
      end
    end else begin
      headPtr  <= headPtr + PTRW'(strb.retireCnt);
      tailPtr  <= tailPtr - PTRW'(strb.popCnt) + insCnt[PTRW-1:0];
      occCount <= occCount - (PTRW+1)'(strb.retireCnt) - (PTRW+1)'(strb.popCnt) + insCnt;
      if (strb.clrCan)
        flags[headPtr + PTRW'(strb.clrOffs)].canCommit <= 1'b0;
      // completions land after the retirement decision of this cycle
      for (int e = 0; e < EXW; e++) begin
        if (cmplValid[e]) begin
          flags[cmplSlot[e*PTRW +: PTRW]].canCommit <= 1'b1;
          if (cmplKill[e]) flags[cmplSlot[e*PTRW +: PTRW]].squashed <= 1'b1;
          else             flags[cmplSlot[e*PTRW +: PTRW]].executed <= 1'b1;
        end
      end
      for (int i = 0; i < RENW; i++) begin
        if (insDo[i]) begin
          flags[insSlot[i]] <= '{canCommit: renStore[i] | renNonSpec[i],
                                 executed: 1'b0, squashed: 1'b0,
                                 isLoad: renLoad[i], isStore: renStore[i],
                                 isNonSpec: renNonSpec[i]};
          seqs[insSlot[i]]  <= renSeq[i*SEQW +: SEQW];
        end
      end
    end
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occCount) <= DEPTH);
  a_r2_room_for_insert: assert property (@(posedge clk) disable iff (!rst_n)
    strb.insertEn |-> (int'(occCount) + RENW <= DEPTH));
  a_r9_removal_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(strb.popCnt) + int'(strb.retireCnt) <= int'(occCount));
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQW  = 8,
  parameter int RENW  = 2,
  parameter int CMTW  = 2,
  parameter int SQW   = 2,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PTRW:0]   occCount,
  input  rob_flags_t      headFlags [CMTW],
  input  logic [SEQW-1:0] headSeq [CMTW],
  input  logic [SEQW-1:0] tailSeq [SQW+1],
  input  logic            exSquash,
  input  logic [SEQW-1:0] exSquashSeq,
  output rob_strobe_t     strb,
  output logic            renReady,
  output logic            doneValid,
  output logic [SEQW-1:0] doneSeq,
  output logic            squashOut,
  output logic            squashBusy,
  output logic            nonSpecValid,
  output logic [SEQW-1:0] nonSpecSeq,
  output logic            loadCommitted
);
  rob_state_e      state, stateNext;
  logic [SEQW-1:0] squashPoint;
  logic            running, stop;
  logic signed [SEQW-1:0] seqDiff;
  int              pops;

  assign running  = (state == ST_RUN);
  assign renReady = running && !exSquash && (int'(occCount) + RENW <= DEPTH);

  always_comb begin
    strb          = '0;
    doneValid     = 1'b0;
    doneSeq       = '0;
    squashOut     = 1'b0;
    squashBusy    = 1'b0;
    nonSpecValid  = 1'b0;
    nonSpecSeq    = '0;
    loadCommitted = 1'b0;
    stateNext     = state;
    stop          = 1'b0;
    pops          = 0;
    seqDiff       = '0;
    if (running) begin
      if (exSquash) begin
        squashOut  = 1'b1;
        squashBusy = 1'b1;
        doneValid  = 1'b1;
        doneSeq    = exSquashSeq;
        stateNext  = ST_SQUASH;
      end else begin
        strb.insertEn = renReady;
        for (int k = 0; k < CMTW; k++) begin
          if (!stop) begin
            if (k >= int'(occCount) || !headFlags[k].canCommit) begin
              stop = 1'b1;
            end else if (headFlags[k].squashed) begin
              if (headFlags[k].executed) strb.retireCnt = strb.retireCnt + STRB_W'(1);
              else                       stop = 1'b1;
            end else if (!headFlags[k].executed) begin
              stop = 1'b1;
              if (headFlags[k].isStore || headFlags[k].isNonSpec) begin
                nonSpecValid = 1'b1;
                nonSpecSeq   = headSeq[k];
                strb.clrCan  = 1'b1;
                strb.clrOffs = STRB_W'(k);
              end
            end else begin
              strb.retireCnt = strb.retireCnt + STRB_W'(1);
              doneValid      = 1'b1;
              doneSeq        = headSeq[k];
              if (headFlags[k].isLoad) loadCommitted = 1'b1;
            end
          end
        end
      end
    end else begin
      // squash walk from the tail, wrap-safe age test
      for (int k = 0; k < SQW; k++) begin
        if (!stop) begin
          seqDiff = $signed(tailSeq[k] - squashPoint);
          if (k < int'(occCount) && seqDiff > 0) pops = pops + 1;
          else stop = 1'b1;
        end
      end
      if (pops == 0) begin
        stateNext = ST_RUN;
      end else begin
        squashBusy  = 1'b1;
        doneValid   = 1'b1;
        doneSeq     = (int'(occCount) > pops) ? tailSeq[pops] : squashPoint;
        strb.popCnt = STRB_W'(pops);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_RUN;
      squashPoint <= '0;
    end else begin
      state <= stateNext;
      if (squashOut) squashPoint <= exSquashSeq;
    end
  end

  a_r8_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    squashOut |-> (strb.retireCnt == '0 && !strb.insertEn && !nonSpecValid));
  a_r6_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    nonSpecValid |=> !(nonSpecValid && nonSpecSeq == $past(nonSpecSeq)));
  a_r9_walk_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.popCnt != '0) |-> (squashBusy && !renReady));
endmodule

// File: rtl/rob_commit.sv
module rob_commit
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQW  = 8,
  parameter int RENW  = 2,
  parameter int EXW   = 2,
  parameter int CMTW  = 2,
  parameter int SQW   = 2,
  parameter int PCW   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [RENW-1:0]              renValid,
  input  logic [RENW-1:0]              renSquashed,
  input  logic [RENW-1:0]              renLoad,
  input  logic [RENW-1:0]              renStore,
  input  logic [RENW-1:0]              renNonSpec,
  input  logic [RENW*SEQW-1:0]         renSeq,
  output logic                         renReady,
  input  logic [EXW-1:0]               cmplValid,
  input  logic [EXW-1:0]               cmplKill,
  input  logic [EXW*$clog2(DEPTH)-1:0] cmplSlot,
  input  logic                         exSquash,
  input  logic [SEQW-1:0]              exSquashSeq,
  input  logic                         exMispredict,
  input  logic                         exTaken,
  input  logic [PCW-1:0]               exNextPc,
  input  logic [PCW-1:0]               exMispredPc,
  output logic [$clog2(DEPTH):0]       freeCount,
  output logic                         doneValid,
  output logic [SEQW-1:0]              doneSeq,
  output logic                         squashOut,
  output logic                         squashBusy,
  output logic                         mispredictOut,
  output logic                         takenOut,
  output logic [PCW-1:0]               nextPcOut,
  output logic [PCW-1:0]               mispredPcOut,
  output logic                         nonSpecValid,
  output logic [SEQW-1:0]              nonSpecSeq,
  output logic                         loadCommitted
);
  localparam int PTRW = $clog2(DEPTH);

  rob_strobe_t     strb;
  rob_flags_t      headFlags [CMTW];
  logic [SEQW-1:0] headSeq [CMTW];
  logic [SEQW-1:0] tailSeq [SQW+1];
  logic [PTRW:0]   occCount;

  rob_ctrl #(.DEPTH(DEPTH), .SEQW(SEQW), .RENW(RENW), .CMTW(CMTW), .SQW(SQW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .occCount(occCount), .headFlags(headFlags),
    .headSeq(headSeq), .tailSeq(tailSeq), .exSquash(exSquash),
    .exSquashSeq(exSquashSeq), .strb(strb), .renReady(renReady),
    .doneValid(doneValid), .doneSeq(doneSeq), .squashOut(squashOut),
    .squashBusy(squashBusy), .nonSpecValid(nonSpecValid),
    .nonSpecSeq(nonSpecSeq), .loadCommitted(loadCommitted)
  );

  rob_store #(.DEPTH(DEPTH), .SEQW(SEQW), .RENW(RENW), .EXW(EXW), .CMTW(CMTW), .SQW(SQW)) u_store (
    .clk(clk), .rst_n(rst_n), .strb(strb), .renValid(renValid),
    .renSquashed(renSquashed), .renLoad(renLoad), .renStore(renStore),
    .renNonSpec(renNonSpec), .renSeq(renSeq), .cmplValid(cmplValid),
    .cmplKill(cmplKill), .cmplSlot(cmplSlot), .headFlags(headFlags),
    .headSeq(headSeq), .tailSeq(tailSeq), .occCount(occCount)
  );

  assign freeCount     = (PTRW+1)'(DEPTH) - occCount;
  assign mispredictOut = squashOut & exMispredict;
  assign takenOut      = squashOut & exTaken;
  assign nextPcOut     = squashOut ? exNextPc    : '0;
  assign mispredPcOut  = squashOut ? exMispredPc : '0;
endmodule

// File: tb/rob_commit_tb.sv
module rob_commit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  rv, rsq, rld, rStore, rns, cv, ck;
  logic [15:0] rSeq;
  logic [5:0]  cSlot;
  logic        exSq, exMis, exTk;
  logic [7:0]  exSqSeq;
  logic [15:0] exNpc, exMpc;
  logic        renReady, doneValid, squashOut, squashBusy, mispredictOut, takenOut;
  logic        nonSpecValid, loadCommitted;
  logic [3:0]  freeCount;
  logic [7:0]  doneSeq, nonSpecSeq;
  logic [15:0] nextPcOut, mispredPcOut;
  int total = 0;
  int bad = 0;

  rob_commit u_dut (
    .clk(clk), .rst_n(rst_n), .renValid(rv), .renSquashed(rsq), .renLoad(rld),
    .renStore(rStore), .renNonSpec(rns), .renSeq(rSeq), .renReady(renReady),
    .cmplValid(cv), .cmplKill(ck), .cmplSlot(cSlot), .exSquash(exSq),
    .exSquashSeq(exSqSeq), .exMispredict(exMis), .exTaken(exTk), .exNextPc(exNpc),
    .exMispredPc(exMpc), .freeCount(freeCount), .doneValid(doneValid),
    .doneSeq(doneSeq), .squashOut(squashOut), .squashBusy(squashBusy),
    .mispredictOut(mispredictOut), .takenOut(takenOut), .nextPcOut(nextPcOut),
    .mispredPcOut(mispredPcOut), .nonSpecValid(nonSpecValid),
    .nonSpecSeq(nonSpecSeq), .loadCommitted(loadCommitted)
  );

  typedef struct packed {
    logic [1:0] rv, rsq, rld, rst, rns;
    logic [7:0] s0, s1;
    logic [1:0] cv, ck;
    logic [2:0] c0, c1;
    logic [3:0] eFree;
    logic       eDv;
    logic [7:0] eDs;
    logic       eLd, eNs;
    logic [7:0] eNsSeq;
  } vec_t;

  localparam vec_t VEC [10] = '{
    // R2: insert 10 (load) and 11 into slots 0 and 1
    '{2'b11, 2'b00, 2'b01, 2'b00, 2'b00, 8'd10, 8'd11, 2'b00, 2'b00, 3'd0, 3'd0, 4'd8, 1'b0, 8'd0, 1'b0, 1'b0, 8'd0},
    // R2: store 12 inserted, lane 1 squashed and skipped; complete slot 0
    '{2'b11, 2'b10, 2'b00, 2'b01, 2'b00, 8'd12, 8'd13, 2'b01, 2'b00, 3'd0, 3'd0, 4'd6, 1'b0, 8'd0, 1'b0, 1'b0, 8'd0},
    // R3: slot 1 completes this cycle, only 10 commits
    '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 8'd0, 8'd0, 2'b01, 2'b00, 3'd1, 3'd0, 4'd5, 1'b1, 8'd10, 1'b1, 1'b0, 8'd0},
    // R6: 11 commits, store 12 requests issue
    '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 8'd0, 8'd0, 2'b00, 2'b00, 3'd0, 3'd0, 4'd6, 1'b1, 8'd11, 1'b0, 1'b1, 8'd12},
    // R6: parked, no repeated request
    '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 8'd0, 8'd0, 2'b00, 2'b00, 3'd0, 3'd0, 4'd7, 1'b0, 8'd0, 1'b0, 1'b0, 8'd0},
    // store completes
    '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 8'd0, 8'd0, 2'b01, 2'b00, 3'd2, 3'd0, 4'd7, 1'b0, 8'd0, 1'b0, 1'b0, 8'd0},
    // store 12 commits, insert 14 and 15 into slots 3 and 4
    '{2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 8'd14, 8'd15, 2'b00, 2'b00, 3'd0, 3'd0, 4'd7, 1'b1, 8'd12, 1'b0, 1'b0, 8'd0},
    '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 8'd0, 8'd0, 2'b11, 2'b00, 3'd3, 3'd4, 4'd6, 1'b0, 8'd0, 1'b0, 1'b0, 8'd0},
    // R4: two commits in one cycle, youngest reported
    '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 8'd0, 8'd0, 2'b00, 2'b00, 3'd0, 3'd0, 4'd6, 1'b1, 8'd15, 1'b0, 1'b0, 8'd0},
    '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 8'd0, 8'd0, 2'b00, 2'b00, 3'd0, 3'd0, 4'd8, 1'b0, 8'd0, 1'b0, 1'b0, 8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    rv = '0; rsq = '0; rld = '0; rStore = '0; rns = '0; rSeq = '0;
    cv = '0; ck = '0; cSlot = '0;
    exSq = 1'b0; exSqSeq = '0; exMis = 1'b0; exTk = 1'b0; exNpc = '0; exMpc = '0;
  endtask

  task automatic ins(input logic [7:0] s0, input logic [7:0] s1);
    rv = 2'b11; rSeq = {s1, s0};
  endtask

  initial begin
    nxt();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 freeCount in reset", freeCount, 8);
    rst_n = 1'b1;
    nxt(); #1;
    chk("R1 freeCount after reset", freeCount, 8);
    chk("R1 renReady after reset", renReady, 1);
    chk("R1 quiet outputs after reset",
        {doneValid, squashOut, squashBusy, nonSpecValid, loadCommitted}, 0);

    for (int i = 0; i < 10; i++) begin
      if (i != 0) nxt();
      rv = VEC[i].rv; rsq = VEC[i].rsq; rld = VEC[i].rld; rStore = VEC[i].rst;
      rns = VEC[i].rns; rSeq = {VEC[i].s1, VEC[i].s0};
      cv = VEC[i].cv; ck = VEC[i].ck; cSlot = {VEC[i].c1, VEC[i].c0};
      #1;
      chk("R10 freeCount", freeCount, VEC[i].eFree);
      chk("R4 doneValid", doneValid, VEC[i].eDv);
      if (VEC[i].eDv) chk("R3 R4 doneSeq", doneSeq, VEC[i].eDs);
      chk("R5 loadCommitted", loadCommitted, VEC[i].eLd);
      chk("R6 nonSpecValid", nonSpecValid, VEC[i].eNs);
      if (VEC[i].eNs) chk("R6 nonSpecSeq", nonSpecSeq, VEC[i].eNsSeq);
    end

    // R7: killed load in slot 5, then 21 in slot 6
    nxt(); ins(8'd20, 8'd21); rld = 2'b01; #1;
    chk("R2 renReady", renReady, 1);
    nxt(); cv = 2'b01; ck = 2'b01; cSlot = 6'd5; #1;
    chk("R7 nothing yet", doneValid, 0);
    nxt(); #1;
    chk("R7 unexecuted killed head blocks", doneValid, 0);
    chk("R7 freeCount while blocked", freeCount, 6);
    nxt(); cv = 2'b11; cSlot = {3'd6, 3'd5}; #1;
    chk("R7 no commit on completion cycle", doneValid, 0);
    nxt(); #1;
    chk("R7 doneSeq skips killed entry", doneSeq, 21);
    chk("R7 no load pulse for killed load", loadCommitted, 0);
    nxt(); #1;
    chk("R7 slots freed", freeCount, 8);

    // R8/R9: 254,255 in slots 7,0; 0,1 in slots 1,2
    nxt(); ins(8'd254, 8'd255);
    nxt(); ins(8'd0, 8'd1); #1;
    chk("R2 renReady before squash", renReady, 1);
    nxt(); ins(8'd50, 8'd51);
    exSq = 1'b1; exSqSeq = 8'd254; exMis = 1'b1; exTk = 1'b1;
    exNpc = 16'h1234; exMpc = 16'h5678; #1;
    chk("R8 squashOut", squashOut, 1);
    chk("R8 squashBusy", squashBusy, 1);
    chk("R8 doneSeq is squash point", doneSeq, 254);
    chk("R8 echo flags", {mispredictOut, takenOut}, 2'b11);
    chk("R8 echo nextPc", nextPcOut, 16'h1234);
    chk("R8 echo mispredPc", mispredPcOut, 16'h5678);
    chk("R8 renReady low", renReady, 0);
    chk("R10 freeCount at squash", freeCount, 4);
    nxt(); #1;
    chk("R9 busy first walk cycle", squashBusy, 1);
    chk("R8 squashOut only one cycle", squashOut, 0);
    chk("R8 echo cleared", {mispredictOut, takenOut, nextPcOut}, 0);
    chk("R9 tail after two removals across wrap", doneSeq, 255);
    chk("R10 freeCount during walk", freeCount, 4);
    nxt(); #1;
    chk("R9 busy second walk cycle", squashBusy, 1);
    chk("R9 tail after third removal", doneSeq, 254);
    chk("R10 freeCount during walk 2", freeCount, 6);
    nxt(); #1;
    chk("R9 walk finished", squashBusy, 0);
    chk("R9 renReady low on finish cycle", renReady, 0);
    chk("R9 freeCount after walk", freeCount, 7);
    nxt(); ins(8'd40, 8'd41); #1;
    chk("R9 renReady back", renReady, 1);
    chk("R2 squash-cycle lanes ignored", freeCount, 7);

    // R2 back-pressure and R1 slot wrap: 40..45 take slots 0..5
    nxt(); ins(8'd42, 8'd43);
    nxt(); ins(8'd44, 8'd45);
    nxt(); ins(8'd46, 8'd47); #1;
    chk("R2 renReady low when full", renReady, 0);
    chk("R10 freeCount near full", freeCount, 1);
    nxt(); cv = 2'b11; cSlot = {3'd0, 3'd7}; #1;
    chk("R2 lanes ignored while not ready", freeCount, 1);
    nxt(); #1;
    chk("R1 slot mapping wraps", doneSeq, 40);
    chk("R4 two commit", doneValid, 1);
    nxt(); #1;
    chk("R10 freeCount after commit", freeCount, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule